// File: doc/BRIEF.md
# PCI Command and Status Register Pair

This block holds the command word and the status word that a host bridge shows in its configuration header. Both words sit in one 32-bit configuration dword. The command word is in the low half (lanes 0 and 1) and the status word is in the high half (lanes 2 and 3). The block decodes a dword-addressed configuration port with byte enables. Reads return data in the same cycle.

Most bits are fixed capability indications: they either read as a constant or cannot be changed.

Two bits in the command word carry behaviour:
- The memory access enable is software-writable. It gates whether the bridge claims main-memory requests that fall inside enabled DRAM space.
- Bus mastering is reported as always on.

The status word has two sticky abort flags, one for a master abort and one for a target abort. Each is set by a one-cycle event strobe from the bridge's master logic and is cleared by writing a one to it. A master abort that ends a special cycle is the normal way such a cycle finishes, so it does not set the flag.

Top module: `pci_cmdsts_regs`

## Requirements
- R1: After reset, a read of the register dword returns 0x0200_0004: status 0x0200 and command 0x0004.
- R2: Command bit 1 (memory access enable) resets to 0. It follows bit 1 of the write data when byte enable 0 is set, and it keeps its value when byte enable 0 is clear.
- R3: Command bits 15:3 and bit 0 always read 0, and command bit 2 always reads 1, whatever is written.
- R4: mem_claim is 1 exactly when mem_req and mem_in_dram are both 1 and the memory access enable is 1.
- R5: A master-abort strobe sets status bit 13 (dword bit 29) on the next clock, unless the special-cycle flag is high in the same cycle; in that case bit 13 is left unchanged.
- R6: A target-abort strobe sets status bit 12 (dword bit 28) on the next clock.
- R7: Status bits 13 and 12 stay set until a write with byte enable 3 set carries a 1 in the matching data bit (29 or 28). Writing a 0 to the bit, or writing with byte enable 3 clear, leaves it set.
- R8: If a set event and a write-one-to-clear reach the same flag in the same clock, the flag ends up set.
- R9: Status bits 10:9 always read 01, and status bits 15:14, 11:5 and 4:0 always read 0, whatever is written.
- R10: A configuration access at any dword address other than CSR_DWORD (default 1) reads 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Configuration dword address |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid in the cycle of cfg_rd |
| ev_master_abort | input | 1 | A bridge-mastered transaction ended in a master abort |
| ev_target_abort | input | 1 | A bridge-mastered transaction ended in a target abort |
| ev_special_cycle | input | 1 | The aborted transaction was a special cycle |
| mem_req | input | 1 | A main-memory access is presented to the bridge |
| mem_in_dram | input | 1 | The access address falls in enabled DRAM space |
| mem_enable | output | 1 | Current memory access enable |
| mem_claim | output | 1 | The bridge claims the memory access |

## Verification
The assertions watch these properties on every clock:
- the fixed bits of both words whenever a read hits;
- that each abort strobe sets its flag, and that a master abort during a special cycle does not set it;
- that a set flag stays set until a matching write-one clear;
- that the enable moves only on a write that hits lane 0.

The bench's scenarios are needed for the following. Its reference model compares every cycle, so it is what shows that a clear happens on the exact data bit and lane, that a set wins a same-cycle race, that accesses to other addresses are ignored, and that the claim output tracks the enable after each write.

// File: rtl/pcicsr_pkg.sv
package pcicsr_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned HALF_W     = 16;
    localparam int unsigned LANES      = DATA_W / 8;

    // command word bit positions
    localparam int unsigned CMD_IOAE   = 0;
    localparam int unsigned CMD_MAE    = 1;
    localparam int unsigned CMD_BME    = 2;

    // status word bit positions
    localparam int unsigned STS_RMAS   = 13;
    localparam int unsigned STS_RTAS   = 12;
    localparam logic [1:0]  DEVT_MED   = 2'b01;
    localparam int unsigned STS_DEVT_LO = 9;

    // sticky flag indices
    localparam int unsigned FLAG_MA    = 0;
    localparam int unsigned FLAG_TA    = 1;
    localparam int unsigned NUM_FLAGS  = 2;

    typedef struct packed {
        logic master;
        logic target;
        logic special;
    } abort_ev_t;

    typedef struct packed {
        logic                  rd_hit;
        logic                  wr_hit;
        logic [LANES-1:0]      be;
        logic [DATA_W-1:0]     data;
    } cfg_acc_t;

    // status-word bit that holds a given sticky flag
    function automatic int unsigned flag_sts_bit(input int unsigned idx);
        return (idx == FLAG_MA) ? STS_RMAS : STS_RTAS;
    endfunction

    // byte lane in the dword that carries a given status bit
    function automatic int unsigned sts_lane(input int unsigned sbit);
        return (HALF_W + sbit) / 8;
    endfunction

    function automatic logic [HALF_W-1:0] build_cmd(input logic mae);
        logic [HALF_W-1:0] w;
        w           = '0;
        w[CMD_BME]  = 1'b1;
        w[CMD_MAE]  = mae;
        w[CMD_IOAE] = 1'b0;
        return w;
    endfunction

    function automatic logic [HALF_W-1:0] build_sts(input logic [NUM_FLAGS-1:0] flags);
        logic [HALF_W-1:0] w;
        w = '0;
        w[STS_DEVT_LO +: 2]  = DEVT_MED;
        w[STS_RMAS]          = flags[FLAG_MA];
        w[STS_RTAS]          = flags[FLAG_TA];
        return w;
    endfunction

endpackage

// File: rtl/pcicsr_decode.sv
module pcicsr_decode
    import pcicsr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned CSR_DWORD = 1
) (
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LANES-1:0]  cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    output cfg_acc_t          acc
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CSR_DWORD);

    logic addr_match;

    always_comb begin
        addr_match  = (cfg_addr == MY_ADDR);
        acc.rd_hit  = cfg_rd & addr_match;
        acc.wr_hit  = cfg_wr & addr_match;
        acc.be      = cfg_be;
        acc.data    = cfg_wdata;
    end

endmodule

// File: rtl/pcicsr_cmd.sv
module pcicsr_cmd (
    input  logic clk,
    input  logic rst,
    input  logic lane_wr,
    input  logic mae_wdata,
    output logic mae_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mae_q <= 1'b0;
        else if (lane_wr)
            mae_q <= mae_wdata;
    end
endmodule

// File: rtl/pcicsr_w1c_flag.sv
module pcicsr_w1c_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_w1,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_ev)
            flag_q <= 1'b1;
        else if (clr_w1)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/pci_cmdsts_regs.sv
module pci_cmdsts_regs
    import pcicsr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned CSR_DWORD = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              ev_master_abort,
    input  logic              ev_target_abort,
    input  logic              ev_special_cycle,
    input  logic              mem_req,
    input  logic              mem_in_dram,
    output logic              mem_enable,
    output logic              mem_claim
);
    localparam int unsigned CMD_LANE = CMD_MAE / 8;

    cfg_acc_t              acc;
    abort_ev_t             ev;
    logic                  mae_q;
    logic [NUM_FLAGS-1:0]  flag_set;
    logic [NUM_FLAGS-1:0]  flag_clr;
    logic [NUM_FLAGS-1:0]  abort_flags_q;

    pcicsr_decode #(
        .ADDR_W    (ADDR_W),
        .CSR_DWORD (CSR_DWORD)
    ) decode_i (
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .acc       (acc)
    );

    always_comb begin
        ev.master  = ev_master_abort;
        ev.target  = ev_target_abort;
        ev.special = ev_special_cycle;
    end

    pcicsr_cmd cmd_i (
        .clk       (clk),
        .rst       (rst),
        .lane_wr   (acc.wr_hit & acc.be[CMD_LANE]),
        .mae_wdata (acc.data[CMD_MAE]),
        .mae_q     (mae_q)
    );

    // a master abort that closes a special cycle is the normal ending
    always_comb begin
        flag_set[FLAG_MA] = ev.master & ~ev.special;
        flag_set[FLAG_TA] = ev.target;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam int unsigned DBIT = HALF_W + flag_sts_bit(i);
        localparam int unsigned LANE = sts_lane(flag_sts_bit(i));

        assign flag_clr[i] = acc.wr_hit & acc.be[LANE] & acc.data[DBIT];

        pcicsr_w1c_flag flag_i (
            .clk    (clk),
            .rst    (rst),
            .set_ev (flag_set[i]),
            .clr_w1 (flag_clr[i]),
            .flag_q (abort_flags_q[i])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        if (acc.rd_hit)
            cfg_rdata = {build_sts(abort_flags_q), build_cmd(mae_q)};
    end

    assign mem_enable = mae_q;
    assign mem_claim  = mem_req & mem_in_dram & mae_q;

endmodule

// File: rtl/pcicsr_chk.sv
module pcicsr_chk #(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned CSR_DWORD = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic              cfg_rd,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic              ev_master_abort,
    input logic              ev_target_abort,
    input logic              ev_special_cycle,
    input logic              mem_req,
    input logic              mem_in_dram,
    input logic              mem_enable,
    input logic              mem_claim,
    input logic [1:0]        abort_flags
);
    logic hit_rd, hit_wr, clr_ma, clr_ta;
    assign hit_rd = cfg_rd && (cfg_addr == ADDR_W'(CSR_DWORD));
    assign hit_wr = cfg_wr && (cfg_addr == ADDR_W'(CSR_DWORD));
    assign clr_ma = hit_wr && cfg_be[3] && cfg_wdata[29];
    assign clr_ta = hit_wr && cfg_be[3] && cfg_wdata[28];

    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && hit_rd) |-> cfg_rdata == 32'h0200_0004); // R1

    AST_ENABLE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(hit_wr && cfg_be[0]) |=> $stable(mem_enable)); // R2

    AST_CMD_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        hit_rd |-> (cfg_rdata[15:0] & 16'hFFFD) == 16'h0004); // R3

    AST_CLAIM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        mem_claim |-> (mem_enable && mem_req && mem_in_dram)); // R4

    AST_MA_SETS: assert property (@(posedge clk) disable iff (rst)
        (ev_master_abort && !ev_special_cycle) |=> abort_flags[0]); // R5

    AST_MA_SPECIAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!abort_flags[0] && ev_special_cycle) |=> !abort_flags[0]); // R5

    AST_TA_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_target_abort |=> abort_flags[1]); // R6

    AST_MA_STICKY: assert property (@(posedge clk) disable iff (rst)
        (abort_flags[0] && !clr_ma) |=> abort_flags[0]); // R7

    AST_TA_STICKY: assert property (@(posedge clk) disable iff (rst)
        (abort_flags[1] && !clr_ta) |=> abort_flags[1]); // R7

    AST_MA_W1C: assert property (@(posedge clk) disable iff (rst)
        (clr_ma && !ev_master_abort) |=> !abort_flags[0]); // R7

    AST_STS_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        hit_rd |-> (cfg_rdata[31:16] & 16'hCFFF) == 16'h0200); // R9

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit_rd |-> cfg_rdata == 32'h0); // R10

endmodule

bind pci_cmdsts_regs pcicsr_chk #(
    .ADDR_W    (ADDR_W),
    .CSR_DWORD (CSR_DWORD)
) chk_i (
    .clk              (clk),
    .rst              (rst),
    .cfg_wr           (cfg_wr),
    .cfg_rd           (cfg_rd),
    .cfg_addr         (cfg_addr),
    .cfg_be           (cfg_be),
    .cfg_wdata        (cfg_wdata),
    .cfg_rdata        (cfg_rdata),
    .ev_master_abort  (ev_master_abort),
    .ev_target_abort  (ev_target_abort),
    .ev_special_cycle (ev_special_cycle),
    .mem_req          (mem_req),
    .mem_in_dram      (mem_in_dram),
    .mem_enable       (mem_enable),
    .mem_claim        (mem_claim),
    .abort_flags      (abort_flags_q)
);

// File: tb/pci_cmdsts_regs_tb_top.sv
module pci_cmdsts_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 0, cfg_rd = 0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ev_ma = 0, ev_ta = 0, ev_sc = 0;
    logic        mem_req = 0, mem_in_dram = 0;
    logic        mem_enable, mem_claim;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";

    // reference model state
    bit m_mae, m_ma, m_ta;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cmdsts_regs dut_i (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ev_master_abort(ev_ma), .ev_target_abort(ev_ta),
        .ev_special_cycle(ev_sc),
        .mem_req(mem_req), .mem_in_dram(mem_in_dram),
        .mem_enable(mem_enable), .mem_claim(mem_claim)
    );

    function automatic logic [31:0] model_rdata();
        logic [31:0] v = '0;
        if (cfg_rd && cfg_addr == 6'd1) begin
            v[2]  = 1'b1;
            v[1]  = m_mae;
            v[25] = 1'b1;
            v[29] = m_ma;
            v[28] = m_ta;
        end
        return v;
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic model_step();
        bit clr_ma, clr_ta;
        bit hit;
        hit    = cfg_wr && cfg_addr == 6'd1;
        clr_ma = hit && cfg_be[3] && cfg_wdata[29];
        clr_ta = hit && cfg_be[3] && cfg_wdata[28];
        if (hit && cfg_be[0]) m_mae = cfg_wdata[1];
        if (ev_ma && !ev_sc) m_ma = 1'b1; else if (clr_ma) m_ma = 1'b0;
        if (ev_ta)           m_ta = 1'b1; else if (clr_ta) m_ta = 1'b0;
    endtask

    // one clock: drive, compare against model, advance model
    task automatic cyc(input logic wr, input logic rd, input logic [5:0] a,
                       input logic [3:0] be, input logic [31:0] d,
                       input logic ma, input logic ta, input logic sc,
                       input logic mr, input logic md);
        cfg_wr = wr; cfg_rd = rd; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        ev_ma = ma; ev_ta = ta; ev_sc = sc; mem_req = mr; mem_in_dram = md;
        #1;
        check32(cur_req, cfg_rdata, model_rdata());
        check32("R4", {30'd0, mem_claim, mem_enable},
                {30'd0, bit'(mr && md && m_mae), m_mae});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic rd_reg(input string req, input logic [31:0] exp);
        cur_req = req;
        cyc(0, 1, 6'd1, 4'h0, 32'h0, 0, 0, 0, 0, 0);
        // literal expectation independent of the model
        cfg_rd = 1; cfg_addr = 6'd1; #1;
        check32(req, cfg_rdata, exp);
        cfg_rd = 0;
    endtask

    task automatic wr_reg(input string req, input logic [5:0] a, input logic [3:0] be,
                          input logic [31:0] d);
        cur_req = req;
        cyc(1, 0, a, be, d, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        m_mae = 0; m_ma = 0; m_ta = 0;

        // R1 reset value
        rd_reg("R1", 32'h0200_0004);

        // R2 enable set through lane 0, R4 claim follows
        wr_reg("R2", 6'd1, 4'h1, 32'h0000_0002);
        rd_reg("R2", 32'h0200_0006);
        cur_req = "R4";
        cyc(0, 0, 6'd1, 4'h0, 0, 0, 0, 0, 1, 1);
        cyc(0, 0, 6'd1, 4'h0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 6'd1, 4'h0, 0, 0, 0, 0, 0, 1);
        // R2 lane 0 disabled: enable kept
        wr_reg("R2", 6'd1, 4'hE, 32'h0000_0000);
        rd_reg("R2", 32'h0200_0006);

        // R3 and R9: all ones, fixed bits unchanged
        wr_reg("R3", 6'd1, 4'hF, 32'hFFFF_FFFF);
        rd_reg("R3", 32'h0200_0006);
        rd_reg("R9", 32'h0200_0006);
        wr_reg("R3", 6'd1, 4'hF, 32'h0000_0000);
        rd_reg("R3", 32'h0200_0004);
        cur_req = "R4";
        cyc(0, 0, 6'd1, 4'h0, 0, 0, 0, 0, 1, 1);

        // R5 master abort sets, special cycle suppresses
        cur_req = "R5";
        cyc(0, 0, 6'd0, 4'h0, 0, 1, 0, 1, 0, 0);
        rd_reg("R5", 32'h0200_0004);
        cur_req = "R5";
        cyc(0, 0, 6'd0, 4'h0, 0, 1, 0, 0, 0, 0);
        rd_reg("R5", 32'h2200_0004);

        // R6 target abort sets
        cur_req = "R6";
        cyc(0, 0, 6'd0, 4'h0, 0, 0, 1, 0, 0, 0);
        rd_reg("R6", 32'h3200_0004);

        // R7 zero data or lane 3 disabled keeps flags; W1C one bit
        wr_reg("R7", 6'd1, 4'hF, 32'h0000_0000);
        wr_reg("R7", 6'd1, 4'h7, 32'h3000_0000);
        rd_reg("R7", 32'h3200_0004);
        wr_reg("R7", 6'd1, 4'h8, 32'h2000_0000);
        rd_reg("R7", 32'h1200_0004);
        wr_reg("R7", 6'd1, 4'h8, 32'h1000_0000);
        rd_reg("R7", 32'h0200_0004);

        // R8 set wins over simultaneous clear
        cur_req = "R8";
        cyc(0, 0, 6'd0, 4'h0, 0, 1, 1, 0, 0, 0);
        cyc(1, 0, 6'd1, 4'h8, 32'h3000_0000, 1, 1, 0, 0, 0);
        rd_reg("R8", 32'h3200_0004);

        // R10 other dword: no write effect, reads zero
        wr_reg("R10", 6'd2, 4'hF, 32'h3000_0002);
        wr_reg("R10", 6'd0, 4'hF, 32'h3000_0002);
        rd_reg("R10", 32'h3200_0004);
        cur_req = "R10";
        cfg_rd = 1; cfg_addr = 6'd3; #1;
        check32("R10", cfg_rdata, 32'h0);
        cfg_rd = 0;
        cyc(0, 1, 6'd5, 4'h0, 0, 0, 0, 0, 1, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule